// File: doc/BRIEF.md
# Functional-Unit Power-Gating Controller

This controller decides, cycle by cycle, whether each of four execution units (ALU, shifter, multiplier, divider) is powered or held in sleep. Each unit has a gating policy of its own, held in a register-mapped policy word. Every issued operation carries a 6-bit power direction that can override that policy for the one operation. When an operation is issued to a sleeping unit, the controller wakes it, and it raises a stall request until the unit is powered again.

Each unit is driven by a four-state machine. `ST_IDLE` means powered with no operation. `ST_BUSY` means powered and executing. `ST_ASLEEP` means the sleep enable is asserted. `ST_WAKING` means power is restored and the unit is counting down the wake latency. The transitions are as follows:
- issue: `ST_IDLE` to `ST_BUSY`, and `ST_BUSY` to itself.
- complete: `ST_BUSY` to `ST_IDLE`, or to `ST_ASLEEP` when the effective policy calls for sleep.
- miss-sleep: `ST_IDLE` to `ST_ASLEEP` under the on-miss policy.
- wake-on-issue and wake-by-policy: `ST_ASLEEP` to `ST_WAKING`.
- ready: `ST_WAKING` to `ST_BUSY` if an operation is pending, otherwise to `ST_IDLE`.

For each unit the block also keeps saturating counters that software can read. They count the cycles spent asleep, the number of sleep episodes, and the short episodes, meaning those no longer than a programmable break-even time. Software uses these counts to tune the policies.

Top module: `fu_pg_ctrl`

## Requirements
- R1: Write address 0 holds the policy word. Each unit has a 2-bit field: ALU in bits 6:5, shifter in bits 8:7, multiplier in bits 10:9, divider in bits 12:11. The encodings are 00 = off after use, 01 = off on miss, 10 or 11 = always on. Reading address 0 returns the fields in place, with every other bit zero.
- R2: After reset, every unit is powered, the stall request is low, every counter reads 0, the policy word reads 0x1540 (all units always on) and the break-even register (write/read address 1) reads BET_RESET.
- R3: Under off-after-use, a unit whose done strobe arrives while it is executing shows its sleep enable high from the next cycle.
- R4: Under off-on-miss, a powered idle unit sleeps from the cycle after it samples the miss input high. If it was put to sleep by a miss, its sleep enable drops in the cycle after the one in which it samples the miss input low.
- R5: Under always on (10 or 11), a unit without a sleep direction never sleeps.
- R6: A direction code of 0x00 sends the unit to sleep when that operation completes. A code of 0x27 keeps it powered. Any other code defers to the policy. Each override applies to its own operation only.
- R7: An issue to a sleeping unit raises the stall request in that cycle. The sleep enable drops in the next cycle, and the stall stays high for WAKE_CYCLES+1 cycles in all.
- R8: Read address 8+u returns the number of cycles unit u (ALU=0, shifter=1, multiplier=2, divider=3) has spent with its sleep enable high.
- R9: Read address 12+u counts the completed sleep episodes of unit u. Read address 16+u counts those whose length in cycles is at most the break-even value.
- R10: Counters saturate at all ones. A write of bit 0 = 1 to address 2 clears every counter on that edge.
- R11: Any read address not listed above returns zero. Reads are combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 2 | Write address: 0 policy, 1 break-even, 2 clear |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 5 | Read address |
| cfg_rdata | output | 32 | Read data |
| iss_vld | input | 4 | Per-unit issue strobe |
| iss_dir | input | 24 | Per-unit 6-bit power direction, unit u in bits 6u+5:6u |
| unit_done | input | 4 | Per-unit operation-complete strobe |
| miss_pend | input | 1 | Cache miss outstanding |
| unit_sleep | output | 4 | Per-unit sleep enable |
| wake_stall | output | 1 | Stall request while an issued unit wakes |

## Verification
A unit state machine stuck in the wrong state shows at the ports within one cycle. A missed sleep, or a sleep that was not asked for, flips `unit_sleep` on the following edge, and a lost pending issue drops `wake_stall` early. Counter faults are slower to surface. An episode closed at the wrong moment, or an off-by-one in the break-even comparison, only appears when the counter is read, so the bench reads a moving address every cycle and compares it with its model. It also targets episodes whose lengths land exactly on the break-even value and one cycle above it.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;
    localparam int NUM_UNITS = 4;
    localparam int DIR_W     = 6;
    localparam int POL_W     = 2;
    localparam int POL_LSB   = 5;
    localparam int DATA_W    = 32;

    localparam logic [DIR_W-1:0] DIR_SLEEP = 6'h00;
    localparam logic [DIR_W-1:0] DIR_STAY  = 6'h27;

    localparam logic [POL_W-1:0] POL_AFTER = 2'b00;
    localparam logic [POL_W-1:0] POL_MISS  = 2'b01;
    localparam logic [POL_W-1:0] POL_ON    = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_ASLEEP,
        ST_WAKING
    } unit_st_e;

    typedef enum logic [1:0] {
        OVR_NONE,
        OVR_SLEEP,
        OVR_STAY
    } ovr_e;

    function automatic ovr_e dir_decode(input logic [DIR_W-1:0] d);
        if (d == DIR_SLEEP)     return OVR_SLEEP;
        else if (d == DIR_STAY) return OVR_STAY;
        else                    return OVR_NONE;
    endfunction
endpackage

// File: rtl/fgc_sat_ctr.sv
`timescale 1ns/1ps
module fgc_sat_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q_o <= '0;
        else if (clr_i)                 q_o <= '0;
        else if (inc_i && (q_o != '1))  q_o <= q_o + 1'b1;
    end

    // R10: a full counter holds its value
    a_r10_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o == '1 && !clr_i) |=> (q_o == '1));
    // R10: clear lands on the same edge
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q_o == '0));
    // R8: no wrap-around without a clear
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (q_o >= $past(q_o)));
endmodule

// File: rtl/fgc_unit_fsm.sv
`timescale 1ns/1ps
module fgc_unit_fsm
    import fgc_pkg::*;
#(
    parameter int WAKE_CYCLES = 2,
    parameter int CNT_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POL_W-1:0] pol_i,
    input  logic [CNT_W-1:0] bet_i,
    input  logic             iss_i,
    input  logic [DIR_W-1:0] dir_i,
    input  logic             done_i,
    input  logic             miss_i,
    output logic             sleep_o,
    output logic             stall_o,
    output logic             asleep_tick_o,
    output logic             ep_end_o,
    output logic             ep_short_o
);
    localparam int WC_W = $clog2(WAKE_CYCLES + 1);

    unit_st_e        st_q, st_n;
    ovr_e            ovr_q, ovr_n, iss_ovr;
    logic            pend_q, pend_n;
    logic            bym_q, bym_n;
    logic [WC_W-1:0] wcnt_q, wcnt_n;
    logic [CNT_W-1:0] eplen_q;
    logic            go_sleep, wake_req;

    // decision taken when the current operation completes
    always_comb begin
        unique case (ovr_q)
            OVR_SLEEP: go_sleep = 1'b1;
            OVR_STAY:  go_sleep = 1'b0;
            default:   go_sleep = (pol_i == POL_AFTER) ||
                                  ((pol_i == POL_MISS) && miss_i);
        endcase
    end

    assign wake_req = pol_i[1] || (bym_q && (!miss_i || (pol_i != POL_MISS)));
    assign iss_ovr  = dir_decode(dir_i);

    // next-state logic
    always_comb begin
        st_n   = st_q;
        ovr_n  = ovr_q;
        pend_n = pend_q;
        bym_n  = bym_q;
        wcnt_n = wcnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (iss_i) begin
                    st_n  = ST_BUSY;
                    ovr_n = iss_ovr;
                end else if ((pol_i == POL_MISS) && miss_i) begin
                    st_n  = ST_ASLEEP;
                    bym_n = 1'b1;
                end
            end
            ST_BUSY: begin
                if (iss_i) begin
                    ovr_n = iss_ovr;
                end else if (done_i) begin
                    ovr_n = OVR_NONE;
                    if (go_sleep) begin
                        st_n  = ST_ASLEEP;
                        bym_n = (ovr_q == OVR_NONE) && (pol_i == POL_MISS);
                    end else begin
                        st_n  = ST_IDLE;
                    end
                end
            end
            ST_ASLEEP: begin
                if (iss_i) begin
                    st_n   = ST_WAKING;
                    wcnt_n = WC_W'(WAKE_CYCLES);
                    pend_n = 1'b1;
                    ovr_n  = iss_ovr;
                end else if (wake_req) begin
                    st_n   = ST_WAKING;
                    wcnt_n = WC_W'(WAKE_CYCLES);
                    pend_n = 1'b0;
                    ovr_n  = OVR_NONE;
                end
            end
            ST_WAKING: begin
                if (iss_i) begin
                    pend_n = 1'b1;
                    ovr_n  = iss_ovr;
                end
                if (wcnt_q == WC_W'(1)) begin
                    st_n  = (pend_q || iss_i) ? ST_BUSY : ST_IDLE;
                    bym_n = 1'b0;
                    pend_n = 1'b0;
                end else begin
                    wcnt_n = wcnt_q - 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ovr_q  <= OVR_NONE;
            pend_q <= 1'b0;
            bym_q  <= 1'b0;
            wcnt_q <= '0;
        end else begin
            st_q   <= st_n;
            ovr_q  <= ovr_n;
            pend_q <= pend_n;
            bym_q  <= bym_n;
            wcnt_q <= wcnt_n;
        end
    end

    // length of the running episode, minus one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   eplen_q <= '0;
        else if (st_q != ST_ASLEEP)   eplen_q <= '0;
        else if (eplen_q != '1)       eplen_q <= eplen_q + 1'b1;
    end

    // outputs
    always_comb begin
        sleep_o       = (st_q == ST_ASLEEP);
        asleep_tick_o = (st_q == ST_ASLEEP);
        stall_o       = ((st_q == ST_ASLEEP) && iss_i) ||
                        ((st_q == ST_WAKING) && (pend_q || iss_i));
        ep_end_o      = (st_q == ST_ASLEEP) && (st_n != ST_ASLEEP);
        ep_short_o    = ep_end_o && (eplen_q < bet_i);
    end

    // R7: an issue to a sleeping unit leaves it powered and stalled next cycle
    a_r7_wake_then_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && iss_i) |=> (!sleep_o && stall_o));
    // R7: leaving sleep always passes through the wake countdown
    a_r7_fall_into_waking: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> (st_q == ST_WAKING));
    // R3: sleep is only entered from a powered, non-waking state
    a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> (($past(st_q) == ST_BUSY) || ($past(st_q) == ST_IDLE)));
    // R5: an idle always-on unit does not fall asleep
    a_r5_idle_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_IDLE) && pol_i[1]) |=> !sleep_o);
endmodule

// File: rtl/fgc_regs.sv
`timescale 1ns/1ps
module fgc_regs
    import fgc_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int BET_RESET = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we_i,
    input  logic [1:0]                          waddr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    input  logic [4:0]                          raddr_i,
    input  logic [NUM_UNITS-1:0][CNT_W-1:0]     sleep_cnt_i,
    input  logic [NUM_UNITS-1:0][CNT_W-1:0]     ep_cnt_i,
    input  logic [NUM_UNITS-1:0][CNT_W-1:0]     short_cnt_i,
    output logic [NUM_UNITS*POL_W-1:0]          pol_o,
    output logic [CNT_W-1:0]                    bet_o,
    output logic                                clr_o,
    output logic [DATA_W-1:0]                   rdata_o
);
    localparam int PW = NUM_UNITS * POL_W;
    localparam logic [PW-1:0] POL_RESET = {NUM_UNITS{POL_ON}};

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_o <= POL_RESET;
            bet_o <= CNT_W'(BET_RESET);
        end else if (we_i) begin
            if (waddr_i == 2'd0) pol_o <= wdata_i[POL_LSB +: PW];
            if (waddr_i == 2'd1) bet_o <= wdata_i[CNT_W-1:0];
        end
    end

    assign clr_o = we_i && (waddr_i == 2'd2) && wdata_i[0];

    always_comb begin
        rdata_o = '0;
        unique case (raddr_i[4:2])
            3'd0: begin
                if (raddr_i[1:0] == 2'd0) rdata_o[POL_LSB +: PW] = pol_o;
                if (raddr_i[1:0] == 2'd1) rdata_o = DATA_W'(bet_o);
            end
            3'd2:    rdata_o = DATA_W'(sleep_cnt_i[raddr_i[1:0]]);
            3'd3:    rdata_o = DATA_W'(ep_cnt_i[raddr_i[1:0]]);
            3'd4:    rdata_o = DATA_W'(short_cnt_i[raddr_i[1:0]]);
            default: rdata_o = '0;
        endcase
    end

    // R1: a policy write is read back with only the field bits populated
    a_r1_policy_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == 2'd0) |=> (pol_o == $past(wdata_i[POL_LSB +: PW])));
endmodule

// File: rtl/fu_pg_ctrl.sv
`timescale 1ns/1ps
module fu_pg_ctrl
    import fgc_pkg::*;
#(
    parameter int WAKE_CYCLES = 2,
    parameter int CNT_W       = 32,
    parameter int BET_RESET   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_waddr,
    input  logic [31:0] cfg_wdata,
    input  logic [4:0]  cfg_raddr,
    output logic [31:0] cfg_rdata,
    input  logic [3:0]  iss_vld,
    input  logic [23:0] iss_dir,
    input  logic [3:0]  unit_done,
    input  logic        miss_pend,
    output logic [3:0]  unit_sleep,
    output logic        wake_stall
);
    logic [NUM_UNITS*POL_W-1:0]          pol;
    logic [CNT_W-1:0]                    bet;
    logic                                clr;
    logic [NUM_UNITS-1:0]                stall, tick, ep_end, ep_short;
    logic [NUM_UNITS-1:0][CNT_W-1:0]     sleep_cnt, ep_cnt, short_cnt;

    fgc_regs #(.CNT_W(CNT_W), .BET_RESET(BET_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .waddr_i(cfg_waddr),
        .wdata_i(cfg_wdata), .raddr_i(cfg_raddr),
        .sleep_cnt_i(sleep_cnt), .ep_cnt_i(ep_cnt), .short_cnt_i(short_cnt),
        .pol_o(pol), .bet_o(bet), .clr_o(clr), .rdata_o(cfg_rdata)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        fgc_unit_fsm #(.WAKE_CYCLES(WAKE_CYCLES), .CNT_W(CNT_W)) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .pol_i(pol[u*POL_W +: POL_W]), .bet_i(bet),
            .iss_i(iss_vld[u]), .dir_i(iss_dir[u*DIR_W +: DIR_W]),
            .done_i(unit_done[u]), .miss_i(miss_pend),
            .sleep_o(unit_sleep[u]), .stall_o(stall[u]),
            .asleep_tick_o(tick[u]), .ep_end_o(ep_end[u]), .ep_short_o(ep_short[u])
        );
        fgc_sat_ctr #(.W(CNT_W)) u_sleep_ctr (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(tick[u]), .q_o(sleep_cnt[u]));
        fgc_sat_ctr #(.W(CNT_W)) u_ep_ctr (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(ep_end[u]), .q_o(ep_cnt[u]));
        fgc_sat_ctr #(.W(CNT_W)) u_short_ctr (
            .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(ep_short[u]), .q_o(short_cnt[u]));

        // R9: short episodes are a subset of all episodes
        a_r9_short_le_all: assert property (@(posedge clk) disable iff (!rst_n)
            short_cnt[u] <= ep_cnt[u]);
    end

    assign wake_stall = |stall;
endmodule

// File: tb/fu_pg_ctrl_bench.sv
`timescale 1ns/1ps
module fu_pg_ctrl_bench;
    localparam int WAKE = 2;
    localparam int CW   = 10;
    localparam int BETR = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_waddr;
    logic [31:0] cfg_wdata;
    logic [4:0]  cfg_raddr;
    logic [31:0] cfg_rdata;
    logic [3:0]  iss_vld;
    logic [5:0]  dir_a [4];
    logic [23:0] iss_dir;
    logic [3:0]  unit_done;
    logic        miss_pend;
    logic [3:0]  unit_sleep;
    logic        wake_stall;

    assign iss_dir = {dir_a[3], dir_a[2], dir_a[1], dir_a[0]};

    fu_pg_ctrl #(.WAKE_CYCLES(WAKE), .CNT_W(CW), .BET_RESET(BETR)) u_fu_pg_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .iss_vld(iss_vld), .iss_dir(iss_dir), .unit_done(unit_done),
        .miss_pend(miss_pend), .unit_sleep(unit_sleep), .wake_stall(wake_stall)
    );

    always #4 clk = ~clk;   // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string cur_req = "R2";

    // reference model: 0 idle, 1 busy, 2 asleep, 3 waking
    int m_st [4], m_w [4], m_pend [4], m_ovr [4], m_bym [4], m_eplen [4];
    int m_sc [4], m_ep [4], m_ms [4], m_pol [4];
    int m_bet;

    function automatic int decode(input logic [5:0] d);
        if (d == 6'h00) return 1;
        if (d == 6'h27) return 2;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int u = 0; u < 4; u++) begin
                m_st[u] = 0; m_w[u] = 0; m_pend[u] = 0; m_ovr[u] = 0; m_bym[u] = 0;
                m_eplen[u] = 0; m_sc[u] = 0; m_ep[u] = 0; m_ms[u] = 0; m_pol[u] = 2;
            end
            m_bet = BETR;
        end else begin
            for (int u = 0; u < 4; u++) begin
                int ov, ns, gs, wk;
                ov = decode(dir_a[u]);
                ns = m_st[u];
                if (m_ovr[u] == 1)      gs = 1;
                else if (m_ovr[u] == 2) gs = 0;
                else gs = (m_pol[u] == 0 || (m_pol[u] == 1 && miss_pend)) ? 1 : 0;
                wk = (m_pol[u] >= 2 || (m_bym[u] == 1 && (!miss_pend || m_pol[u] != 1))) ? 1 : 0;
                case (m_st[u])
                    0: if (iss_vld[u]) begin ns = 1; m_ovr[u] = ov; end
                       else if (m_pol[u] == 1 && miss_pend) begin ns = 2; m_bym[u] = 1; end
                    1: if (iss_vld[u]) m_ovr[u] = ov;
                       else if (unit_done[u]) begin
                           if (gs == 1) begin
                               ns = 2;
                               m_bym[u] = (m_ovr[u] == 0 && m_pol[u] == 1) ? 1 : 0;
                           end else ns = 0;
                           m_ovr[u] = 0;
                       end
                    2: if (iss_vld[u]) begin ns = 3; m_w[u] = WAKE; m_pend[u] = 1; m_ovr[u] = ov; end
                       else if (wk == 1) begin ns = 3; m_w[u] = WAKE; m_pend[u] = 0; m_ovr[u] = 0; end
                    default: begin
                        int p;
                        p = m_pend[u] | int'(iss_vld[u]);
                        if (iss_vld[u]) begin m_pend[u] = 1; m_ovr[u] = ov; end
                        if (m_w[u] == 1) begin
                            ns = (p != 0) ? 1 : 0; m_bym[u] = 0; m_pend[u] = 0;
                        end else m_w[u] = m_w[u] - 1;
                    end
                endcase
                if (m_st[u] == 2) begin
                    if (m_sc[u] < CMAX) m_sc[u]++;
                    if (ns != 2) begin
                        if (m_ep[u] < CMAX) m_ep[u]++;
                        if (m_eplen[u] + 1 <= m_bet && m_ms[u] < CMAX) m_ms[u]++;
                    end
                    if (m_eplen[u] < CMAX) m_eplen[u]++;
                end else m_eplen[u] = 0;
                if (cfg_we && cfg_waddr == 2 && cfg_wdata[0]) begin
                    m_sc[u] = 0; m_ep[u] = 0; m_ms[u] = 0;
                end
                m_st[u] = ns;
            end
            if (cfg_we && cfg_waddr == 0)
                for (int u = 0; u < 4; u++) m_pol[u] = int'((cfg_wdata >> (5 + 2*u)) & 3);
            if (cfg_we && cfg_waddr == 1) m_bet = int'(cfg_wdata & CMAX);
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] a);
        logic [31:0] r;
        r = 0;
        if (a == 0) for (int u = 0; u < 4; u++) r = r | (32'(m_pol[u]) << (5 + 2*u));
        else if (a == 1) r = 32'(m_bet);
        else if (a >= 8 && a < 12) r = 32'(m_sc[a-8]);
        else if (a >= 12 && a < 16) r = 32'(m_ep[a-12]);
        else if (a >= 16 && a < 20) r = 32'(m_ms[a-16]);
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [3:0] es;
        logic est;
        es = 0; est = 0;
        for (int u = 0; u < 4; u++) begin
            es[u] = (m_st[u] == 2);
            if ((m_st[u] == 2 && iss_vld[u]) || (m_st[u] == 3 && (m_pend[u] != 0 || iss_vld[u]))) est = 1;
        end
        chk(cur_req, "unit_sleep vs model", 32'(unit_sleep), 32'(es));
        chk(cur_req, "wake_stall vs model", 32'(wake_stall), 32'(est));
        chk(cur_req, "cfg_rdata vs model", cfg_rdata, model_read(cfg_raddr));
    endtask

    task automatic tick();
        #2;
        compare_all();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cfg_we = 0; cfg_waddr = 0; cfg_wdata = 0; cfg_raddr = 0;
        iss_vld = 0; unit_done = 0; miss_pend = 0;
        for (int u = 0; u < 4; u++) dir_a[u] = 6'h15;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        cfg_raddr = a;
        #1 chk(req, "register read", cfg_rdata, exp);
        tick();
    endtask

    task automatic issue(input int u, input logic [5:0] d);
        iss_vld[u] = 1; dir_a[u] = d;
        tick();
        iss_vld[u] = 0; dir_a[u] = 6'h15;
    endtask

    task automatic done_pulse(input int u);
        unit_done[u] = 1;
        tick();
        unit_done[u] = 0;
    endtask

    task automatic wake_seq(input int u, input string req);
        iss_vld[u] = 1; dir_a[u] = 6'h15;
        #1 chk(req, "stall in issue cycle", 32'(wake_stall), 1);
        tick();
        iss_vld[u] = 0;
        #1 chk(req, "sleep dropped after issue", 32'(unit_sleep[u]), 0);
        chk(req, "stall in first wake cycle", 32'(wake_stall), 1);
        tick();
        #1 chk(req, "stall in last wake cycle", 32'(wake_stall), 1);
        tick();
        #1 chk(req, "stall released when ready", 32'(wake_stall), 0);
        tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 0;
        idle_in();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        cur_req = "R2";
        #1 chk("R2", "sleep after reset", 32'(unit_sleep), 0);
        chk("R2", "stall after reset", 32'(wake_stall), 0);
        tick();
        rd_chk(0, 32'h1540, "R1");
        rd_chk(1, BETR, "R2");
        rd_chk(8, 0, "R2");
        rd_chk(19, 0, "R2");
        rd_chk(5, 0, "R11");
        rd_chk(31, 0, "R11");

        // always on, both encodings
        cur_req = "R5";
        issue(0, 6'h15); tick(); done_pulse(0);
        #1 chk("R5", "ALU awake under 10", 32'(unit_sleep[0]), 0);
        tick();
        wr(0, 32'h1540 | (32'd3 << 5));
        issue(0, 6'h15); done_pulse(0); tick();
        #1 chk("R5", "ALU awake under 11", 32'(unit_sleep[0]), 0);
        tick();

        // off after use, episodes and break-even
        cur_req = "R3";
        wr(0, 32'h1500);
        issue(0, 6'h15); done_pulse(0);
        #1 chk("R3", "ALU asleep after done", 32'(unit_sleep[0]), 1);
        tick(); tick(); tick();
        cur_req = "R7";
        wake_seq(0, "R7");
        rd_chk(8, 4, "R8");
        rd_chk(12, 1, "R9");
        rd_chk(16, 1, "R9");   // length 4 equals break-even 4
        wr(1, 2);
        cur_req = "R9";
        done_pulse(0); tick(); tick(); tick();
        wake_seq(0, "R7");
        rd_chk(12, 2, "R9");
        rd_chk(16, 1, "R9");   // length 4 above break-even 2
        done_pulse(0); tick();
        wake_seq(0, "R7");
        rd_chk(16, 2, "R9");   // length 2 equals break-even 2
        rd_chk(8, 10, "R8");

        // direction overrides on the divider
        cur_req = "R6";
        issue(3, 6'h00); done_pulse(3);
        #1 chk("R6", "0x00 sleeps under always on", 32'(unit_sleep[3]), 1);
        tick();
        iss_vld[3] = 1; dir_a[3] = 6'h27; tick(); iss_vld[3] = 0; dir_a[3] = 6'h15;
        tick(); tick(); done_pulse(3);
        #1 chk("R6", "0x27 keeps unit powered", 32'(unit_sleep[3]), 0);
        tick();
        wr(0, 32'h0500);
        issue(3, 6'h27); done_pulse(3);
        #1 chk("R6", "0x27 overrides off-after-use", 32'(unit_sleep[3]), 0);
        tick();
        issue(3, 6'h15); done_pulse(3);
        #1 chk("R6", "override lasted one op only", 32'(unit_sleep[3]), 1);
        tick();

        // off on miss on the shifter
        cur_req = "R4";
        wr(0, 32'h0480);
        miss_pend = 1; tick();
        #1 chk("R4", "shifter sleeps on miss", 32'(unit_sleep[1]), 1);
        tick(); tick();
        miss_pend = 0; tick();
        #1 chk("R4", "shifter wakes after miss", 32'(unit_sleep[1]), 0);
        chk("R4", "no stall on miss wake", 32'(wake_stall), 0);
        tick();

        // policy field layout
        cur_req = "R1";
        wr(0, 32'hFFFF_FFFF);
        rd_chk(0, 32'h0000_1FE0, "R1");
        wr(0, 32'h1540);

        // random traffic against the model
        cur_req = "R8";
        for (int i = 0; i < 600; i++) begin
            int r;
            cfg_we = ($urandom % 8 == 0);
            cfg_waddr = 2'($urandom % 3);
            cfg_wdata = (cfg_waddr == 1) ? ($urandom % 8) : $urandom;
            cfg_raddr = 5'($urandom % 24);
            miss_pend = ($urandom % 3 == 0);
            for (int u = 0; u < 4; u++) begin
                iss_vld[u] = ($urandom % 5 == 0);
                unit_done[u] = ($urandom % 3 == 0);
                r = $urandom % 3;
                dir_a[u] = (r == 0) ? 6'h00 : (r == 1) ? 6'h27 : 6'($urandom);
            end
            tick();
        end
        idle_in();

        // settle every unit to idle, then clear and saturate
        cur_req = "R10";
        wr(0, 32'h1540);
        repeat (6) tick();
        unit_done = 4'hF; tick(); unit_done = 0;
        repeat (6) tick();
        wr(2, 1);
        rd_chk(8, 0, "R10");
        rd_chk(13, 0, "R10");
        rd_chk(18, 0, "R10");
        wr(0, 32'h1500);
        issue(0, 6'h15); done_pulse(0);
        repeat (1100) tick();
        rd_chk(8, CMAX, "R10");
        wake_seq(0, "R7");
        rd_chk(12, 1, "R9");
        rd_chk(16, 0, "R9");

        summary();
    end
endmodule